// File: doc/BRIEF.md
# RS-485 Transceiver Direction Controller

This block steers the driver-enable line of an external half-duplex RS-485 transceiver while the UART it serves runs in 9-bit multidrop mode. It watches three events from the transmit path: a level that says the shift register holds data, a one-cycle pulse for every bit time, and a one-cycle pulse when the final stop bit has left the shift register. From these it keeps a direction state: transmit, receive, or a turnaround countdown between the two.

Once the final stop bit is out, the block loads a programmable 8-bit delay and counts it down on bit-time pulses. When the count is exhausted it returns the transceiver to receive. If new data starts during the countdown, the countdown is dropped and the line stays in transmit. The direction level can be inverted, and it can drive either the RTS or the DTR output. The output that is not selected, and both outputs when control is off, carry the software values unchanged.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: During and directly after reset the controller is in the receive state with a zero count, so the selected pin shows the receive level.
- R2: With `cfg_invert` = 0 the selected pin is 0 while transmitting or counting down and 1 while receiving.
- R3: With `cfg_invert` = 1 the selected pin is 1 while transmitting or counting down and 0 while receiving. Polarity changes take effect combinationally.
- R4: `tx_active` high at a clock edge in the receive or countdown state puts the controller in transmit after that edge.
- R5: A `tx_last_stop` pulse in the transmit state loads `cfg_turn_delay` = N. The pin stays at the transmit level until the (N+1)th `bit_tick` after that edge, and the receive level appears right after the edge that samples that tick.
- R6: With N = 0 the pin returns to receive on the first `bit_tick` after the stop-bit edge. A tick in the same cycle as the stop pulse does not count.
- R7: `tx_active` during the countdown abandons it and takes priority over a tick in the same cycle. A later stop pulse reloads the full delay.
- R8: `cfg_use_dtr` = 0 routes the direction to `rts_out` and `dtr_out` = `sw_dtr`. A value of 1 routes it to `dtr_out` and `rts_out` = `sw_rts`.
- R9: When `cfg_multidrop_en` or `cfg_drive_en` is 0, `rts_out` = `sw_rts` and `dtr_out` = `sw_dtr`, and the state returns to receive at the next edge.
- R10: `bit_tick` in the receive or transmit state and `tx_active` in the transmit state have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_multidrop_en | input | 1 | 9-bit multidrop mode on |
| cfg_drive_en | input | 1 | Transmitter owns the direction pin |
| cfg_invert | input | 1 | Invert direction polarity |
| cfg_use_dtr | input | 1 | 0: RTS carries direction, 1: DTR |
| cfg_turn_delay | input | 8 | Turnaround delay in bit times |
| tx_active | input | 1 | Transmit shift register holds data |
| bit_tick | input | 1 | One pulse per bit time |
| tx_last_stop | input | 1 | Pulse when the final stop bit has left |
| sw_rts | input | 1 | Software RTS value |
| sw_dtr | input | 1 | Software DTR value |
| rts_out | output | 1 | RTS pin |
| dtr_out | output | 1 | DTR pin |

## Verification
The state moves at the clock edge that samples an event, and the pins follow the state combinationally. A stimulus driven before an edge therefore shows on the pins right after that edge, and configuration or software-value changes show within the same cycle. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. For changes that apply within the cycle, it samples 1 ns after driving and before any rising edge. The countdown rows are laid out so that the release is expected exactly after the edge that samples the (N+1)th tick.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [1:0] {
    DIR_RX   = 2'd0,
    DIR_TX   = 2'd1,
    DIR_TURN = 2'd2
  } dir_state_e;

  // Physical level of the direction pin: transmit -> 0 unless inverted.
  function automatic logic pin_level(input logic drive_tx, input logic invert);
    return invert ? drive_tx : ~drive_tx;
  endfunction

  // True when a tick ends the countdown (count already exhausted).
  function automatic logic turn_done(input logic tick, input logic cnt_zero);
    return tick & cnt_zero;
  endfunction

endpackage

// File: rtl/rs485_turn_fsm.sv
module rs485_turn_fsm
  import rs485_dir_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tx_active,
  input  logic             bit_tick,
  input  logic             tx_last_stop,
  input  logic [CNT_W-1:0] delay,
  output dir_state_e       state_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             drive_tx
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  dir_state_e       state_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_zero;
  logic             release_ev;
  logic             restart_ev;
  logic             stop_ev;

  assign cnt_zero   = (cnt_q == CNT_ZERO);
  assign stop_ev    = (state_q == DIR_TX) && tx_last_stop;
  assign restart_ev = (state_q == DIR_TURN) && tx_active;
  assign release_ev = (state_q == DIR_TURN) && !tx_active && turn_done(bit_tick, cnt_zero);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en) begin
      state_d = DIR_RX;
      cnt_d   = CNT_ZERO;
    end else begin
      unique case (state_q)
        DIR_RX: if (tx_active) state_d = DIR_TX;
        DIR_TX: if (tx_last_stop) begin
          state_d = DIR_TURN;
          cnt_d   = delay;
        end
        DIR_TURN: begin
          if (restart_ev) begin
            state_d = DIR_TX;
          end else if (release_ev) begin
            state_d = DIR_RX;
          end else if (bit_tick) begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        default: state_d = DIR_RX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIR_RX;
      cnt_q   <= CNT_ZERO;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign drive_tx = (state_q != DIR_RX);

  // R5: a stop pulse in transmit enters the countdown with the delay loaded
  a_r5_stop_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (en && stop_ev) |=> (state_q == DIR_TURN && cnt_q == $past(delay)));

  // R5: each tick with a non-zero count lowers it by one
  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == DIR_TURN && !tx_active && bit_tick && !cnt_zero)
      |=> (state_q == DIR_TURN && cnt_q == $past(cnt_q) - CNT_ONE));

  // R6: a tick on an exhausted count releases to receive
  a_r6_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == DIR_TURN && !tx_active && bit_tick && cnt_zero)
      |=> (state_q == DIR_RX));

  // R7: new data during the countdown returns to transmit
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en && restart_ev) |=> (state_q == DIR_TX));

  // R9: losing control forces receive
  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_q == DIR_RX && cnt_zero));

  // R10: tx_active in transmit holds the state when no stop pulse arrives
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state_q == DIR_TX && !tx_last_stop) |=> (state_q == DIR_TX));

endmodule

// File: rtl/rs485_pin_mux.sv
module rs485_pin_mux
  import rs485_dir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic use_dtr,
  input  logic invert,
  input  logic drive_tx,
  input  logic sw_rts,
  input  logic sw_dtr,
  output logic rts_out,
  output logic dtr_out
);

  logic dir_lvl;
  logic own_rts;
  logic own_dtr;

  assign dir_lvl = pin_level(drive_tx, invert);
  assign own_rts = en && !use_dtr;
  assign own_dtr = en && use_dtr;

  assign rts_out = own_rts ? dir_lvl : sw_rts;
  assign dtr_out = own_dtr ? dir_lvl : sw_dtr;

  // R8: the unselected pin always carries its software value
  a_r8_rts_free: assert property (@(posedge clk) disable iff (!rst_n)
    (en && use_dtr) |-> (rts_out == sw_rts));
  a_r8_dtr_free: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !use_dtr) |-> (dtr_out == sw_dtr));

  // R9: with control off both pins follow software
  a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (rts_out == sw_rts && dtr_out == sw_dtr));

  // R2 R3: the owned pins differ exactly when the direction differs
  a_r3_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !use_dtr) |-> (rts_out == (drive_tx ^ !invert)));

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_multidrop_en,
  input  logic             cfg_drive_en,
  input  logic             cfg_invert,
  input  logic             cfg_use_dtr,
  input  logic [CNT_W-1:0] cfg_turn_delay,
  input  logic             tx_active,
  input  logic             bit_tick,
  input  logic             tx_last_stop,
  input  logic             sw_rts,
  input  logic             sw_dtr,
  output logic             rts_out,
  output logic             dtr_out
);

  logic             ctl_active;
  dir_state_e       fsm_state;
  logic [CNT_W-1:0] fsm_cnt;
  logic             fsm_drive_tx;

  assign ctl_active = cfg_multidrop_en && cfg_drive_en;

  rs485_turn_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (ctl_active),
    .tx_active    (tx_active),
    .bit_tick     (bit_tick),
    .tx_last_stop (tx_last_stop),
    .delay        (cfg_turn_delay),
    .state_q      (fsm_state),
    .cnt_q        (fsm_cnt),
    .drive_tx     (fsm_drive_tx)
  );

  rs485_pin_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctl_active),
    .use_dtr  (cfg_use_dtr),
    .invert   (cfg_invert),
    .drive_tx (fsm_drive_tx),
    .sw_rts   (sw_rts),
    .sw_dtr   (sw_dtr),
    .rts_out  (rts_out),
    .dtr_out  (dtr_out)
  );

  // R4: transmit data leaves receive at the next edge
  a_r4_start_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_active && fsm_state == DIR_RX && tx_active) |=> fsm_drive_tx);

  // R1: receive state reports the receive direction
  a_r1_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == DIR_RX) |-> !fsm_drive_tx && (fsm_cnt == '0 || ctl_active));

endmodule

// File: tb/sim_rs485_dir_ctrl.sv
`timescale 1ns/1ps
module sim_rs485_dir_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_multidrop_en = 1'b1;
  logic       cfg_drive_en = 1'b1;
  logic       cfg_invert = 1'b0;
  logic       cfg_use_dtr = 1'b0;
  logic [7:0] cfg_turn_delay = 8'd2;
  logic       tx_active = 1'b0;
  logic       bit_tick = 1'b0;
  logic       tx_last_stop = 1'b0;
  logic       sw_rts = 1'b0;
  logic       sw_dtr = 1'b0;
  logic       rts_out;
  logic       dtr_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rs485_dir_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_multidrop_en(cfg_multidrop_en), .cfg_drive_en(cfg_drive_en),
    .cfg_invert(cfg_invert), .cfg_use_dtr(cfg_use_dtr),
    .cfg_turn_delay(cfg_turn_delay),
    .tx_active(tx_active), .bit_tick(bit_tick), .tx_last_stop(tx_last_stop),
    .sw_rts(sw_rts), .sw_dtr(sw_dtr),
    .rts_out(rts_out), .dtr_out(dtr_out)
  );

  // {tx_active, bit_tick, tx_last_stop, expect_transmit}; delay 2, normal, RTS
  localparam int NV = 17;
  localparam logic [3:0] VEC [NV] = '{
    4'b0000, 4'b0100, 4'b1001, 4'b1101, 4'b0011,
    4'b0101, 4'b0001, 4'b0101, 4'b0100,
    4'b1001, 4'b0011, 4'b0101, 4'b1101,
    4'b0011, 4'b0101, 4'b0101, 4'b0100
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic a, input logic t, input logic s);
    @(negedge clk);
    tx_active = a; bit_tick = t; tx_last_stop = s;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rts receive in reset", rts_out, 1'b1);
    chk("R1 dtr passthrough in reset", dtr_out, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 rts receive after reset", rts_out, 1'b1);

    // R2 R4 R5 R7 R10 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][3], VEC[i][2], VEC[i][1]);
      chk($sformatf("R2 R4 R5 R7 R10 row %0d rts", i), rts_out, ~VEC[i][0]);
      chk($sformatf("R8 row %0d dtr", i), dtr_out, sw_dtr);
    end

    // R3 inverted polarity
    @(negedge clk); cfg_invert = 1'b1; #1;
    chk("R3 inverted receive", rts_out, 1'b0);
    step(1, 0, 0);
    chk("R3 inverted transmit", rts_out, 1'b1);
    step(0, 0, 1);
    chk("R3 inverted countdown", rts_out, 1'b1);
    step(0, 1, 0); step(0, 1, 0); step(0, 1, 0);
    chk("R3 inverted released", rts_out, 1'b0);
    @(negedge clk); cfg_invert = 1'b0;

    // R6 zero delay, tick with stop pulse ignored
    cfg_turn_delay = 8'd0;
    step(1, 0, 0);
    step(0, 1, 1);
    chk("R6 tick with stop ignored", rts_out, 1'b0);
    step(0, 0, 0);
    chk("R6 waiting for tick", rts_out, 1'b0);
    step(0, 1, 0);
    chk("R6 first tick releases", rts_out, 1'b1);

    // R8 DTR selection
    @(negedge clk); cfg_use_dtr = 1'b1; sw_rts = 1'b1; bit_tick = 1'b0; #1;
    chk("R8 dtr receive", dtr_out, 1'b1);
    chk("R8 rts free high", rts_out, 1'b1);
    @(negedge clk); sw_rts = 1'b0; #1;
    chk("R8 rts free low", rts_out, 1'b0);
    step(1, 0, 0);
    chk("R8 dtr transmit", dtr_out, 1'b0);
    chk("R8 rts untouched", rts_out, 1'b0);
    step(0, 0, 1);
    step(0, 1, 0);
    chk("R8 dtr released", dtr_out, 1'b1);
    @(negedge clk); cfg_use_dtr = 1'b0; sw_dtr = 1'b1;

    // R9 drive enable off mid-transmit
    step(1, 0, 0);
    chk("R9 transmit before disable", rts_out, 1'b0);
    @(negedge clk); cfg_drive_en = 1'b0; sw_rts = 1'b1; #1;
    chk("R9 rts passthrough", rts_out, 1'b1);
    chk("R9 dtr passthrough", dtr_out, 1'b1);
    @(posedge clk); #1;
    @(negedge clk); cfg_drive_en = 1'b1; #1;
    chk("R9 back in receive", rts_out, 1'b1);
    // R9 multidrop off
    step(1, 0, 0);
    @(negedge clk); cfg_multidrop_en = 1'b0; sw_rts = 1'b0; sw_dtr = 1'b0; #1;
    chk("R9 multidrop off rts", rts_out, 1'b0);
    chk("R9 multidrop off dtr", dtr_out, 1'b0);
    @(posedge clk); #1;
    @(negedge clk); tx_active = 1'b0; cfg_multidrop_en = 1'b1; #1;
    chk("R9 multidrop back receive", rts_out, 1'b1);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule